// File: doc/BRIEF.md
# Reset Supervisor with Free-Running Watchdog

This block decides when a processor is held in reset. It gives one active-low, open-drain request (`rst_drive_low` high means the pin is pulled low). Three causes can raise it. The first is a supply-good input from an outside comparator. The second is a manual reset, seen as a low level on the bidirectional reset pin. The third is a programmable watchdog. Two tick inputs from outside set the time scale. `tick_slow` marks the 100 ms period used for stretching and for the watchdog. `tick_fast` is used to debounce the manual input.

Software programs the block through a small write port with two register selects.

- **Select 0, restart and flags.** Bits 3:0 are the restart nibble. Bit 7 is the watchdog-reset flag. Bit 6 is the supply/manual-reset flag.
- **Select 1, control.** Bit 7 is the watchdog enable. Bits 4:0 are the timeout field, in units of slow ticks.

The watchdog counter always runs. Only the key nibble `1010` restarts it, and that same write copies the timeout field into the active period. Both flags are sticky. Only software clears them.

A four-state machine controls the pin:

| State | Pin | Transition out |
|---|---|---|
| HOLD | driven low | Leaves when supply is good, to STRETCH. |
| STRETCH | driven low | Leaves on the last counted slow tick, to GUARD. |
| GUARD | released, pin still ignored | Leaves on the first fast tick, to IDLE. |
| IDLE | released, causes watched | An accepted manual reset or an enabled watchdog expiry goes to STRETCH. |

From any state, supply loss goes to HOLD.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `rst_drive_low` is 1 from the next clock onward. The POR flag (select 0, bit 6) is set.
- R2: After `supply_ok` returns to 1, `rst_drive_low` stays 1 until PULSE_TICKS+1 slow ticks have been seen. It drops on the clock after the last of those ticks. With the default of 1, that is the second tick.
- R3: A manual reset is accepted only after the synchronized pin has been low at DEB_TICKS consecutive fast ticks. Fewer ticks do nothing. An accepted request sets POR and starts the same stretch as R2.
- R4: The pin level is ignored while the block drives the pin, and until the first fast tick after release. The block's own pulse therefore cannot trigger another one.
- R5: The watchdog expires on the Nth slow tick after a restart, where N is the active timeout. N = 0 behaves as 1, and N = 31 stops the counter.
- R6: Writing select 0 with bits 3:0 = `1010` clears the watchdog count and loads the active period from the timeout field. The upper nibble does not matter. Other nibbles, and writes to the timeout field alone, leave the timer unchanged.
- R7: With the enable bit (select 1, bit 7) at 0, the counter still counts and wraps, but never drives reset. An expiry drives a stretch only when the bit is 1.
- R8: The watchdog count is held at zero while the pin is driven or supply is low. A full period therefore starts when a reset pulse ends.
- R9: A watchdog reset sets WTR (select 0, bit 7). Both flags can be set at once. Each flag is cleared only by writing 0 to its bit. Writing 1 has no effect, and a set in the same cycle wins.
- R10: After `rst_n` the timeout field reads 1Fh, the enable bit and both flags read 0, and the pin is driven (state HOLD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's logic |
| supply_ok | input | 1 | Supply above trip point, synchronous |
| tick_slow | input | 1 | One-cycle pulse every 100 ms |
| tick_fast | input | 1 | One-cycle debounce pulse |
| pin_in | input | 1 | Level read back from the reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects restart/flags, 1 selects control |
| wr_data | input | 8 | Write data |
| rst_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low |
| wd_enable | output | 1 | Watchdog enable bit |
| wd_timeout | output | 5 | Timeout field |
| flag_wtr | output | 1 | Watchdog-reset flag |
| flag_por | output | 1 | Supply or manual reset flag |

## Verification
The bench sweeps timeout values 0 through 6 and counts slow ticks to the pulse. A design that read 0 as zero length, or was off by one tick, would fire one tick early or late. It also shows that a non-key nibble or a bare timeout write changes nothing. It shows that a disabled counter still wraps: enabling it mid-period fires on the next tick, where a design that paused when disabled would wait a full period. A supply dip partway through a period must give a full period afterwards. A debounce one tick short, and fast ticks during the design's own pulse, must both leave the pin released. Flags are written with 1s and then with 0s to catch a flag that clears on write or one that can be set by software.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_GUARD   = 2'd2,
        ST_IDLE    = 2'd3
    } rsv_state_e;

    localparam int          TMO_W       = 5;
    localparam logic [3:0]  RESTART_KEY = 4'b1010;
    localparam logic [TMO_W-1:0] TMO_STOP = {TMO_W{1'b1}};
    localparam logic        SEL_KICK    = 1'b0;
    localparam logic        SEL_CTRL    = 1'b1;
    localparam int          BIT_WTR     = 7;
    localparam int          BIT_POR     = 6;
    localparam int          BIT_EN      = 7;
endpackage

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic tick_fast,
    input  logic ignore_pin,
    output logic accept
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          pin_low;

    assign pin_low = ~sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin_in};
        end
    end

    assign accept = tick_fast && pin_low && !ignore_pin && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ignore_pin || !pin_low) begin
            cnt_q <= '0;
        end else if (tick_fast) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
    import rsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow,
    input  logic             hold_clear,
    input  logic             restart,
    input  logic [TMO_W-1:0] tmo_field,
    output logic             expire
);
    logic [TMO_W-1:0] act_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] period;
    logic             stopped;
    logic             at_end;

    assign stopped = (act_q == TMO_STOP);
    assign period  = (act_q == '0) ? TMO_W'(1) : act_q;
    assign at_end  = (cnt_q == period - TMO_W'(1));
    assign expire  = tick_slow && !stopped && !restart && !hold_clear && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= TMO_STOP;
            cnt_q <= '0;
        end else if (restart) begin
            act_q <= tmo_field;
            cnt_q <= '0;
        end else if (hold_clear) begin
            cnt_q <= '0;
        end else if (tick_slow && !stopped) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsv_regs.sv
module rsv_regs
    import rsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             set_wtr,
    input  logic             set_por,
    output logic             restart,
    output logic [TMO_W-1:0] tmo_field,
    output logic             wd_en,
    output logic             flag_wtr,
    output logic             flag_por
);
    logic kick_wr;
    logic ctrl_wr;

    assign kick_wr = wr_en && (wr_sel == SEL_KICK);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign restart = kick_wr && (wr_data[3:0] == RESTART_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_field <= TMO_STOP;
            wd_en     <= 1'b0;
        end else if (ctrl_wr) begin
            tmo_field <= wr_data[TMO_W-1:0];
            wd_en     <= wr_data[BIT_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_wtr <= 1'b0;
            flag_por <= 1'b0;
        end else begin
            if (set_wtr) begin
                flag_wtr <= 1'b1;
            end else if (kick_wr && !wr_data[BIT_WTR]) begin
                flag_wtr <= 1'b0;
            end
            if (set_por) begin
                flag_por <= 1'b1;
            end else if (kick_wr && !wr_data[BIT_POR]) begin
                flag_por <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
    import rsv_pkg::*;
#(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick_slow,
    input  logic tick_fast,
    input  logic manual_accept,
    input  logic wd_expire,
    input  logic wd_en,
    output logic drive_low,
    output logic ignore_pin,
    output logic set_por,
    output logic set_wtr
);
    localparam int END_CNT = PULSE_TICKS + 1;
    localparam int CW      = $clog2(END_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(END_CNT - 1);

    rsv_state_e    state_q;
    rsv_state_e    state_d;
    logic [CW-1:0] cnt_q;
    logic          wd_fire;

    assign wd_fire = wd_expire && wd_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (supply_ok) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (tick_slow && cnt_q == LAST) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (tick_fast) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (manual_accept || wd_fire) state_d = ST_STRETCH;
            end
        endcase
        if (!supply_ok) state_d = ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_STRETCH || state_d != ST_STRETCH) begin
                cnt_q <= '0;
            end else if (tick_slow) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        drive_low  = (state_q == ST_HOLD) || (state_q == ST_STRETCH);
        ignore_pin = (state_q != ST_IDLE);
        set_por    = !supply_ok || ((state_q == ST_IDLE) && manual_accept);
        set_wtr    = (state_q == ST_IDLE) && wd_fire;
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int PULSE_TICKS = 1,
    parameter int DEB_TICKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             pin_in,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic             rst_drive_low,
    output logic             wd_enable,
    output logic [TMO_W-1:0] wd_timeout,
    output logic             flag_wtr,
    output logic             flag_por
);
    logic manual_accept;
    logic ignore_pin;
    logic wd_expire;
    logic restart;
    logic set_por;
    logic set_wtr;
    logic hold_clear;

    assign hold_clear = rst_drive_low || !supply_ok;

    rsv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .tick_fast  (tick_fast),
        .ignore_pin (ignore_pin),
        .accept     (manual_accept)
    );

    rsv_wdog u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_slow  (tick_slow),
        .hold_clear (hold_clear),
        .restart    (restart),
        .tmo_field  (wd_timeout),
        .expire     (wd_expire)
    );

    rsv_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .set_wtr   (set_wtr),
        .set_por   (set_por),
        .restart   (restart),
        .tmo_field (wd_timeout),
        .wd_en     (wd_enable),
        .flag_wtr  (flag_wtr),
        .flag_por  (flag_por)
    );

    rsv_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok     (supply_ok),
        .tick_slow     (tick_slow),
        .tick_fast     (tick_fast),
        .manual_accept (manual_accept),
        .wd_expire     (wd_expire),
        .wd_en         (wd_enable),
        .drive_low     (rst_drive_low),
        .ignore_pin    (ignore_pin),
        .set_por       (set_por),
        .set_wtr       (set_wtr)
    );
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       tick_slow,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       rst_drive_low,
    input logic       wd_enable,
    input logic       flag_wtr,
    input logic       flag_por
);
    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_drive_low); // R1

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_low) |-> $past(tick_slow)); // R2

    AST_PULSE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_drive_low) |-> (flag_por || flag_wtr)); // R9

    AST_WTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wtr) |-> $past(wd_enable)); // R7

    AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_por && !(wr_en && !wr_sel && !wr_data[6])) |=> flag_por); // R9

    AST_WTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wtr && !(wr_en && !wr_sel && !wr_data[7])) |=> flag_wtr); // R9
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .tick_slow     (tick_slow),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rst_drive_low (rst_drive_low),
    .wd_enable     (wd_enable),
    .flag_wtr      (flag_wtr),
    .flag_por      (flag_por)
);

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;
    localparam int DEB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       button = 1'b0;
    logic       pin_in;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_drive_low;
    logic       wd_enable;
    logic [4:0] wd_timeout;
    logic       flag_wtr;
    logic       flag_por;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign pin_in = ~(rst_drive_low | button);

    rst_supervisor #(.PULSE_TICKS(1), .DEB_TICKS(DEB)) u_rst_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .tick_slow(tick_slow), .tick_fast(tick_fast), .pin_in(pin_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rst_drive_low(rst_drive_low), .wd_enable(wd_enable),
        .wd_timeout(wd_timeout), .flag_wtr(flag_wtr), .flag_por(flag_por)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic slow_tick();
        @(negedge clk) tick_slow = 1'b1;
        @(negedge clk) tick_slow = 1'b0;
    endtask

    task automatic fast_tick();
        @(negedge clk) tick_fast = 1'b1;
        @(negedge clk) tick_fast = 1'b0;
    endtask

    task automatic write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic finish_pulse(input string req);
        slow_tick();
        slow_tick();
        check(req, rst_drive_low, 0);
        fast_tick();
        write(1'b0, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 drive", rst_drive_low, 1);
        check("R10 timeout", wd_timeout, 31);
        check("R10 enable", wd_enable, 0);
        check("R10 wtr", flag_wtr, 0);

        // R1 / R2 supply stretch
        supply_ok = 1'b1;
        idle(2);
        check("R1 por set", flag_por, 1);
        slow_tick();
        check("R2 still held after one tick", rst_drive_low, 1);
        finish_pulse("R2 released after second tick");
        check("R9 por cleared", flag_por, 0);

        // R5 sweep of timeouts 0..6
        for (int n = 0; n <= 6; n++) begin
            int per;
            per = (n == 0) ? 1 : n;
            write(1'b1, 8'h80 | 8'(n));
            write(1'b0, 8'h0A);
            for (int k = 1; k < per; k++) slow_tick();
            check($sformatf("R5 n=%0d before expiry", n), rst_drive_low, 0);
            slow_tick();
            check($sformatf("R5 n=%0d expiry", n), rst_drive_low, 1);
            check($sformatf("R9 n=%0d wtr", n), flag_wtr, 1);
            finish_pulse("R5 release");
        end

        // R7 disabled counter wraps freely
        write(1'b1, 8'h02);
        write(1'b0, 8'h0A);
        for (int k = 0; k < 5; k++) slow_tick();
        check("R7 disabled no reset", rst_drive_low, 0);
        check("R7 disabled no wtr", flag_wtr, 0);
        write(1'b1, 8'h82);
        slow_tick();
        check("R7 enabled mid-period fires", rst_drive_low, 1);
        finish_pulse("R7 release");

        // R6 non-key nibble and bare field write
        write(1'b1, 8'h83);
        write(1'b0, 8'h0A);
        slow_tick();
        slow_tick();
        write(1'b0, 8'hC5);
        write(1'b1, 8'h81);
        check("R6 no reset yet", rst_drive_low, 0);
        slow_tick();
        check("R6 old period kept", rst_drive_low, 1);
        finish_pulse("R6 release");
        write(1'b0, 8'hFA);
        slow_tick();
        check("R6 key loads new period", rst_drive_low, 1);
        finish_pulse("R6 release2");

        // R5 stop value
        write(1'b1, 8'h9F);
        write(1'b0, 8'h0A);
        for (int k = 0; k < 40; k++) slow_tick();
        check("R5 stop value never fires", rst_drive_low, 0);

        // R8 supply dip clears the count
        write(1'b1, 8'h82);
        write(1'b0, 8'h0A);
        slow_tick();
        @(negedge clk) supply_ok = 1'b0;
        for (int k = 0; k < 3; k++) slow_tick();
        check("R1 held during dip", rst_drive_low, 1);
        @(negedge clk) supply_ok = 1'b1;
        finish_pulse("R2 release after dip");
        slow_tick();
        check("R8 full period after dip", rst_drive_low, 0);
        slow_tick();
        check("R8 expiry after full period", rst_drive_low, 1);
        check("R9 both flags wtr", flag_wtr, 1);
        write(1'b0, 8'hC0);
        check("R9 por only after watchdog", flag_por, 0);
        check("R9 write 1 keeps wtr", flag_wtr, 1);
        write(1'b0, 8'h40);
        check("R9 write 0 clears wtr", flag_wtr, 0);
        finish_pulse("R8 release");

        // R9 both flags together
        write(1'b1, 8'h81);
        write(1'b0, 8'h0A);
        slow_tick();
        @(negedge clk) supply_ok = 1'b0;
        idle(2);
        check("R9 both wtr", flag_wtr, 1);
        check("R9 both por", flag_por, 1);
        @(negedge clk) supply_ok = 1'b1;
        write(1'b1, 8'h1F);
        write(1'b0, 8'h0A);
        finish_pulse("R9 release");
        check("R9 cleared both", flag_wtr + flag_por, 0);

        // R3 debounce
        @(negedge clk) button = 1'b1;
        idle(3);
        for (int k = 0; k < DEB - 1; k++) fast_tick();
        check("R3 short press ignored", rst_drive_low, 0);
        @(negedge clk) button = 1'b0;
        idle(3);
        fast_tick();
        @(negedge clk) button = 1'b1;
        idle(3);
        for (int k = 0; k < DEB; k++) fast_tick();
        check("R3 long press accepted", rst_drive_low, 1);
        check("R3 por set", flag_por, 1);
        @(negedge clk) button = 1'b0;

        // R4 own pulse does not retrigger
        for (int k = 0; k < DEB + 2; k++) fast_tick();
        check("R4 still stretching", rst_drive_low, 1);
        slow_tick();
        slow_tick();
        check("R4 released", rst_drive_low, 0);
        for (int k = 0; k < DEB + 3; k++) fast_tick();
        check("R4 no retrigger", rst_drive_low, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule